// File: doc/BRIEF.md
# SDRAM Multi-Bank Command Legality Monitor

This block watches the command bus of a single data rate SDRAM. On every clock it decodes the chip-select, row-strobe, column-strobe and write-enable pins, the bank address and the A10 bit into one command. It keeps a small state machine with its own down-counter for each bank. A command to one bank is judged against that bank's state and, where the command reaches across banks, against the states of the others. When a command breaks the rules the monitor raises a one-cycle violation strobe and a code that says which rule was broken.

The activate-to-column delay, the precharge time, the burst length and the self-refresh exit time arrive as input counts, so one instance can follow whatever timing the memory controller has programmed. A command that is judged illegal leaves every bank state as it was. The monitor only observes the bus. It does not check the data path, schedule refreshes or enforce power-down rules.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: A cycle with CS# high (inhibit), or with CS# low and RAS#, CAS# and WE# all high (no-op), never raises `viol` and changes no bank state.
- R2: Commands are decoded from {CS#, RAS#, CAS#, WE#}: activate 0011, read 0101, write 0100, precharge 0010, burst stop 0110, refresh 0001, mode-register load 0000. A10 high on a read or write selects auto precharge. A10 high on a precharge targets every bank and ignores `ba`.
- R3: When `rst_n` is low at a clock edge, every bank goes idle. Bank b reports its state in `bank_state[3b+2:3b]` with the encoding idle 0, activating 1, row active 2, read 3, write 4, read with auto precharge 5, write with auto precharge 6, precharging 7.
- R4: A violation found in the command at edge t shows on `viol` and `viol_code` from edge t until edge t+1 and no longer. The codes are 0 none, 1 no open row, 2 row already open, 3 bank busy, 4 not all banks idle, 5 no burst to stop. An illegal command changes no state.
- R5: An activate to an idle bank makes it activating, and it becomes row active `rcd_cycles` clocks after the activate. A read or write to a bank that is idle, activating or precharging gives code 1. An activate to a bank that is activating, row active, reading or writing gives code 2.
- R6: A precharge moves each targeted bank that is activating, row active, reading or writing into precharging, and that bank becomes idle `rp_cycles` clocks after the precharge. A precharge to an idle or precharging bank is legal and has no effect. An activate to a precharging bank gives code 3.
- R7: A read or write with auto precharge holds the bank in its auto-precharge state for `burst_cycles + rp_cycles` clocks, after which the bank is idle. An activate, read, write or single-bank precharge to that bank gives code 3, and so does an all-bank precharge while any bank is in an auto-precharge state.
- R8: Commands to one bank are legal while other banks are active, bursting or precharging. A new read or write returns any other bank that has a burst without auto precharge to row active, so at most one such burst exists at a time.
- R9: Burst stop ignores `ba` and ends the running burst that has no auto precharge, returning that bank to row active. With no such burst running it gives code 5.
- R10: Refresh, mode-register load and self-refresh entry (the refresh encoding sampled with CKE falling) give code 4 unless every bank is idle.
- R11: A command is judged only when CKE was high on the previous clock and is high on this one. The one exception is self-refresh entry, which is judged on the clock where CKE falls. A command that is not judged is ignored.
- R12: After a legal self-refresh entry, commands are ignored on the first `xsr_cycles + 1` clocks that sample CKE high.
- R13: A read or write without auto precharge keeps the bank in read or write for `burst_cycles` clocks, after which the bank is row active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| a10 | input | 1 | Auto-precharge / all-bank select bit |
| rcd_cycles | input | CNT_W | Activate-to-column delay in clocks |
| rp_cycles | input | CNT_W | Precharge time in clocks |
| burst_cycles | input | CNT_W | Burst length in clocks |
| xsr_cycles | input | CNT_W | Self-refresh exit time in clocks |
| bank_state | output | 3*NUM_BANKS | Packed per-bank state |
| viol | output | 1 | Violation strobe |
| viol_code | output | 3 | Violation code |

## Verification
The bench targets the edges of each timed window: a read one clock before the activating state ends, an activate one clock before a precharge completes, and the last clock of an auto-precharge window. A design with a counter off by one would flag a legal command there or pass an illegal one. It also targets cross-bank effects. A read to a second bank must cut the first bank's burst, or the next burst stop would be judged against the wrong bank. An all-bank precharge must be refused while another bank is auto-precharging. The bench drives commands on clocks where CKE falls, where CKE rises, and inside the self-refresh exit window. A monitor that ignores CKE history would report violations that the memory itself never saw.

// File: rtl/sdmon_pkg.sv
// Shared types for the SDRAM command monitor: decoded commands, bank
// states, violation codes and the per-bank action a command causes.
// Assumes 3-bit state and code encodings are visible on the top ports.
package sdmon_pkg;

    typedef enum logic [2:0] {
        BS_IDLE    = 3'd0,
        BS_OPENING = 3'd1,
        BS_OPEN    = 3'd2,
        BS_RD      = 3'd3,
        BS_WR      = 3'd4,
        BS_RD_AP   = 3'd5,
        BS_WR_AP   = 3'd6,
        BS_CLOSING = 3'd7
    } bank_st_e;

    typedef enum logic [3:0] {
        CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE,
        CMD_BT, CMD_REF, CMD_LMR, CMD_SREF
    } cmd_e;

    typedef enum logic [2:0] {
        VC_NONE      = 3'd0,
        VC_NO_ROW    = 3'd1,
        VC_ROW_OPEN  = 3'd2,
        VC_BUSY      = 3'd3,
        VC_NOT_IDLE  = 3'd4,
        VC_NO_BURST  = 3'd5
    } viol_e;

    typedef enum logic [2:0] {
        BA_NONE, BA_OPEN, BA_RD, BA_WR, BA_RD_AP, BA_WR_AP, BA_CLOSE, BA_END
    } bank_act_e;

    // True while a row is open or opening (precharge has work to do).
    function automatic logic has_row(bank_st_e s);
        return (s == BS_OPENING) || (s == BS_OPEN) || (s == BS_RD) || (s == BS_WR);
    endfunction

    // True for a burst without auto precharge.
    function automatic logic plain_burst(bank_st_e s);
        return (s == BS_RD) || (s == BS_WR);
    endfunction

    // True for either auto-precharge state.
    function automatic logic auto_pre(bank_st_e s);
        return (s == BS_RD_AP) || (s == BS_WR_AP);
    endfunction

endpackage

// File: rtl/sdmon_decode.sv
// Turns the four command pins and CKE history into one decoded command.
// The refresh encoding sampled while CKE falls becomes self-refresh entry.
module sdmon_decode
    import sdmon_pkg::*;
(
    input  logic cke,
    input  logic cke_q,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    // Pin pattern to command.
    always_comb begin
        cmd = CMD_NOP;
        if (!cs_n) begin
            unique case ({ras_n, cas_n, we_n})
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b010:  cmd = CMD_PRE;
                3'b110:  cmd = CMD_BT;
                3'b001:  cmd = (cke_q && !cke) ? CMD_SREF : CMD_REF;
                3'b000:  cmd = CMD_LMR;
                default: cmd = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/sdmon_judge.sv
// Judges a decoded command against all bank states. It yields a violation
// code and, for a legal command, the action each bank must take.
// Assumes en is low for commands that must be ignored.
module sdmon_judge
    import sdmon_pkg::*;
#(
    parameter int NB   = 4,
    parameter int BA_W = 2
) (
    input  logic            en,
    input  cmd_e            cmd,
    input  logic [BA_W-1:0] ba,
    input  logic            a10,
    input  bank_st_e        st  [NB],
    output viol_e           code,
    output bank_act_e       act [NB]
);

    logic     any_ap;
    logic     any_burst;
    logic     all_idle;
    bank_st_e tgt;

    // Summaries over all banks and the addressed bank's state.
    always_comb begin
        any_ap    = 1'b0;
        any_burst = 1'b0;
        all_idle  = 1'b1;
        for (int b = 0; b < NB; b++) begin
            any_ap    = any_ap | auto_pre(st[b]);
            any_burst = any_burst | plain_burst(st[b]);
            all_idle  = all_idle & (st[b] == BS_IDLE);
        end
        tgt = st[ba];
    end

    // Legality of the command.
    always_comb begin
        code = VC_NONE;
        unique case (cmd)
            CMD_ACT: begin
                if (has_row(tgt))          code = VC_ROW_OPEN;
                else if (tgt != BS_IDLE)   code = VC_BUSY;
            end
            CMD_RD, CMD_WR: begin
                if (auto_pre(tgt))         code = VC_BUSY;
                else if (!(tgt == BS_OPEN || plain_burst(tgt))) code = VC_NO_ROW;
            end
            CMD_PRE: begin
                if (a10 ? any_ap : auto_pre(tgt)) code = VC_BUSY;
            end
            CMD_BT: begin
                if (!any_burst)            code = VC_NO_BURST;
            end
            CMD_REF, CMD_LMR, CMD_SREF: begin
                if (!all_idle)             code = VC_NOT_IDLE;
            end
            default: code = VC_NONE;
        endcase
        if (!en) code = VC_NONE;
    end

    // Per-bank effect of a legal, judged command.
    always_comb begin
        for (int b = 0; b < NB; b++) begin
            act[b] = BA_NONE;
            if (en && code == VC_NONE) begin
                unique case (cmd)
                    CMD_ACT: if (ba == BA_W'(b)) act[b] = BA_OPEN;
                    CMD_RD, CMD_WR: begin
                        if (ba == BA_W'(b)) begin
                            if (cmd == CMD_RD) act[b] = a10 ? BA_RD_AP : BA_RD;
                            else               act[b] = a10 ? BA_WR_AP : BA_WR;
                        end else if (plain_burst(st[b])) begin
                            act[b] = BA_END;
                        end
                    end
                    CMD_PRE: if ((a10 || ba == BA_W'(b)) && has_row(st[b])) act[b] = BA_CLOSE;
                    CMD_BT:  if (plain_burst(st[b])) act[b] = BA_END;
                    default: act[b] = BA_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/sdmon_bank.sv
// One bank's state machine with its own down-counter. A timed state holds
// for the loaded count and then falls to its exit state. Assumes the judge
// only sends actions that are legal for the current state.
module sdmon_bank
    import sdmon_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  bank_act_e        act_i,
    input  logic [CNT_W-1:0] rcd_i,
    input  logic [CNT_W-1:0] rp_i,
    input  logic [CNT_W-1:0] bl_i,
    output bank_st_e         st_o
);

    localparam int LW = CNT_W + 1;

    bank_st_e        st, nxt_st, timed_st, tgt_st;
    logic [LW-1:0]   cnt, nxt_cnt, load;
    logic            use_load;
    logic [LW-1:0]   rcd_m1, rp_m1, bl_x;

    // Hold lengths derived from the programmed counts.
    always_comb begin
        bl_x   = {1'b0, bl_i};
        rcd_m1 = (rcd_i == '0) ? '0 : ({1'b0, rcd_i} - LW'(1));
        rp_m1  = (rp_i  == '0) ? '0 : ({1'b0, rp_i}  - LW'(1));
    end

    // Next state and count from the action or the running timer.
    always_comb begin
        nxt_st   = st;
        nxt_cnt  = cnt;
        use_load = 1'b0;
        load     = '0;
        timed_st = BS_IDLE;
        tgt_st   = BS_IDLE;
        unique case (act_i)
            BA_OPEN:  begin use_load = 1'b1; load = rcd_m1;        timed_st = BS_OPENING; tgt_st = BS_OPEN; end
            BA_RD:    begin use_load = 1'b1; load = bl_x;          timed_st = BS_RD;      tgt_st = BS_OPEN; end
            BA_WR:    begin use_load = 1'b1; load = bl_x;          timed_st = BS_WR;      tgt_st = BS_OPEN; end
            BA_RD_AP: begin use_load = 1'b1; load = bl_x + rp_m1;  timed_st = BS_RD_AP;   tgt_st = BS_IDLE; end
            BA_WR_AP: begin use_load = 1'b1; load = bl_x + rp_m1;  timed_st = BS_WR_AP;   tgt_st = BS_IDLE; end
            BA_CLOSE: begin use_load = 1'b1; load = rp_m1;         timed_st = BS_CLOSING; tgt_st = BS_IDLE; end
            BA_END:   begin nxt_st = BS_OPEN; nxt_cnt = '0; end
            default: begin
                if (st != BS_IDLE && st != BS_OPEN) begin
                    if (cnt <= LW'(1)) begin
                        nxt_st  = (st == BS_OPENING || plain_burst(st)) ? BS_OPEN : BS_IDLE;
                        nxt_cnt = '0;
                    end else begin
                        nxt_cnt = cnt - LW'(1);
                    end
                end
            end
        endcase
        if (use_load) begin
            if (load == '0) begin
                nxt_st  = tgt_st;
                nxt_cnt = '0;
            end else begin
                nxt_st  = timed_st;
                nxt_cnt = load;
            end
        end
    end

    // State register with synchronous reset to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= BS_IDLE;
            cnt <= '0;
        end else begin
            st  <= nxt_st;
            cnt <= nxt_cnt;
        end
    end

    assign st_o = st;

endmodule

// File: rtl/sdram_cmd_monitor.sv
// Top of the SDRAM command legality monitor. It tracks CKE history and the
// self-refresh exit window, judges each command and registers the result.
// Assumes NUM_BANKS is a power of two of at least 2.
module sdram_cmd_monitor
    import sdmon_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int CNT_W     = 6,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cke,
    input  logic                   cs_n,
    input  logic                   ras_n,
    input  logic                   cas_n,
    input  logic                   we_n,
    input  logic [BA_W-1:0]        ba,
    input  logic                   a10,
    input  logic [CNT_W-1:0]       rcd_cycles,
    input  logic [CNT_W-1:0]       rp_cycles,
    input  logic [CNT_W-1:0]       burst_cycles,
    input  logic [CNT_W-1:0]       xsr_cycles,
    output logic [3*NUM_BANKS-1:0] bank_state,
    output logic                   viol,
    output logic [2:0]             viol_code
);

    logic             cke_q;
    logic             sr_flag;
    logic [CNT_W-1:0] xsr_cnt;
    logic             judge_en;
    cmd_e             dec_cmd;
    viol_e            code;
    bank_st_e         bank_st  [NUM_BANKS];
    bank_act_e        bank_act [NUM_BANKS];

    sdmon_decode u_decode (
        .cke   (cke),
        .cke_q (cke_q),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (dec_cmd)
    );

    // Commands count only with CKE high twice, or on self-refresh entry.
    assign judge_en = cke_q && (xsr_cnt == '0) && (cke || dec_cmd == CMD_SREF);

    sdmon_judge #(.NB(NUM_BANKS), .BA_W(BA_W)) u_judge (
        .en   (judge_en),
        .cmd  (dec_cmd),
        .ba   (ba),
        .a10  (a10),
        .st   (bank_st),
        .code (code),
        .act  (bank_act)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        sdmon_bank #(.CNT_W(CNT_W)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .act_i (bank_act[b]),
            .rcd_i (rcd_cycles),
            .rp_i  (rp_cycles),
            .bl_i  (burst_cycles),
            .st_o  (bank_st[b])
        );
        assign bank_state[3*b +: 3] = bank_st[b];
    end

    // CKE history, self-refresh tracking and the exit window counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cke_q   <= cke;
            sr_flag <= 1'b0;
            xsr_cnt <= '0;
        end else begin
            cke_q <= cke;
            if (judge_en && dec_cmd == CMD_SREF && code == VC_NONE) begin
                sr_flag <= 1'b1;
            end else if (sr_flag && cke && !cke_q) begin
                sr_flag <= 1'b0;
                xsr_cnt <= xsr_cycles;
            end else if (xsr_cnt != '0) begin
                xsr_cnt <= xsr_cnt - CNT_W'(1);
            end
        end
    end

    // Registered violation strobe and code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol      <= 1'b0;
            viol_code <= 3'd0;
        end else begin
            viol      <= (code != VC_NONE);
            viol_code <= code;
        end
    end

endmodule

// File: rtl/sdmon_checker.sv
// Assertions for the SDRAM command monitor, attached to its top by bind.
// Assumes the top's internal judge enable and decoded command are visible.
module sdmon_checker
    import sdmon_pkg::*;
#(
    parameter int NB = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cs_n,
    input logic            judge_en,
    input cmd_e            dec_cmd,
    input logic [3*NB-1:0] bank_state,
    input logic            viol,
    input logic [2:0]      viol_code
);

    logic [NB-1:0] burst_vec;
    logic          all_idle;

    always_comb begin
        all_idle = 1'b1;
        for (int b = 0; b < NB; b++) begin
            burst_vec[b] = (bank_state[3*b +: 3] == 3'd3) || (bank_state[3*b +: 3] == 3'd4);
            all_idle     = all_idle & (bank_state[3*b +: 3] == 3'd0);
        end
    end

    assert_inhibit_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !viol);

    assert_reset_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (bank_state == '0 && !viol));

    assert_code_present_R4: assert property (@(posedge clk) disable iff (!rst_n)
        viol |-> (viol_code != 3'd0));

    assert_single_burst_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(burst_vec) <= 1);

    assert_global_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (judge_en && (dec_cmd == CMD_REF || dec_cmd == CMD_LMR || dec_cmd == CMD_SREF) && !all_idle)
        |=> (viol && viol_code == 3'd4));

    assert_gated_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !judge_en |=> !viol);

    for (genvar b = 0; b < NB; b++) begin : g_bank_chk
        assert_idle_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (bank_state[3*b +: 3] == 3'd0) |=>
            (bank_state[3*b +: 3] inside {3'd0, 3'd1, 3'd2}));

        assert_close_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (bank_state[3*b +: 3] == 3'd7) |=>
            (bank_state[3*b +: 3] inside {3'd7, 3'd0}));

        assert_ap_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (bank_state[3*b +: 3] inside {3'd5, 3'd6}) |=>
            (bank_state[3*b +: 3] == $past(bank_state[3*b +: 3]) || bank_state[3*b +: 3] == 3'd0));
    end

endmodule

bind sdram_cmd_monitor sdmon_checker #(.NB(NUM_BANKS)) u_sdmon_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .judge_en   (judge_en),
    .dec_cmd    (dec_cmd),
    .bank_state (bank_state),
    .viol       (viol),
    .viol_code  (viol_code)
);

// File: tb/sdram_cmd_monitor_bench.sv
`timescale 1ns/1ps
module sdram_cmd_monitor_bench;

    localparam int NB = 4;
    localparam int CW = 6;

    localparam logic [3:0] P_NOP = 4'b0111, P_ACT = 4'b0011, P_RD  = 4'b0101,
                           P_WR  = 4'b0100, P_PRE = 4'b0010, P_BT  = 4'b0110,
                           P_REF = 4'b0001, P_LMR = 4'b0000, P_INH = 4'b1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cke = 1'b1;
    logic [3:0] pins = P_NOP;
    logic [1:0] ba = '0;
    logic a10 = 1'b0;
    logic [3*NB-1:0] bank_state;
    logic viol;
    logic [2:0] viol_code;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    sdram_cmd_monitor #(.NUM_BANKS(NB), .CNT_W(CW)) u_sdram_cmd_monitor (
        .clk (clk), .rst_n (rst_n), .cke (cke),
        .cs_n (pins[3]), .ras_n (pins[2]), .cas_n (pins[1]), .we_n (pins[0]),
        .ba (ba), .a10 (a10),
        .rcd_cycles (6'd2), .rp_cycles (6'd2), .burst_cycles (6'd4), .xsr_cycles (6'd2),
        .bank_state (bank_state), .viol (viol), .viol_code (viol_code)
    );

    // Vector: {req[3:0], pins[3:0], ba[1:0], a10, expected code[2:0]}
    // Timing in use: activate delay 2, precharge 2, burst 4.
    localparam int NV = 29;
    localparam logic [13:0] VEC [NV] = '{
        {4'd1,  P_NOP, 2'd0, 1'b0, 3'd0},
        {4'd5,  P_RD,  2'd0, 1'b0, 3'd1},
        {4'd9,  P_BT,  2'd0, 1'b0, 3'd5},
        {4'd5,  P_ACT, 2'd0, 1'b0, 3'd0},
        {4'd5,  P_RD,  2'd0, 1'b0, 3'd1},
        {4'd5,  P_ACT, 2'd0, 1'b0, 3'd2},
        {4'd8,  P_ACT, 2'd1, 1'b0, 3'd0},
        {4'd10, P_REF, 2'd0, 1'b0, 3'd4},
        {4'd13, P_RD,  2'd0, 1'b0, 3'd0},
        {4'd8,  P_RD,  2'd1, 1'b0, 3'd0},
        {4'd9,  P_BT,  2'd3, 1'b0, 3'd0},
        {4'd9,  P_BT,  2'd1, 1'b0, 3'd5},
        {4'd7,  P_WR,  2'd1, 1'b1, 3'd0},
        {4'd7,  P_RD,  2'd1, 1'b0, 3'd3},
        {4'd7,  P_PRE, 2'd1, 1'b0, 3'd3},
        {4'd2,  P_PRE, 2'd0, 1'b1, 3'd3},
        {4'd6,  P_PRE, 2'd0, 1'b0, 3'd0},
        {4'd6,  P_ACT, 2'd0, 1'b0, 3'd3},
        {4'd10, P_LMR, 2'd0, 1'b0, 3'd0},
        {4'd5,  P_ACT, 2'd2, 1'b0, 3'd0},
        {4'd6,  P_PRE, 2'd2, 1'b0, 3'd0},
        {4'd1,  P_INH, 2'd0, 1'b0, 3'd0},
        {4'd5,  P_ACT, 2'd3, 1'b0, 3'd0},
        {4'd1,  P_NOP, 2'd0, 1'b0, 3'd0},
        {4'd13, P_WR,  2'd3, 1'b0, 3'd0},
        {4'd2,  P_PRE, 2'd1, 1'b1, 3'd0},
        {4'd10, P_REF, 2'd0, 1'b0, 3'd4},
        {4'd10, P_REF, 2'd0, 1'b0, 3'd0},
        {4'd6,  P_PRE, 2'd0, 1'b0, 3'd0}
    };

    function automatic string tag(logic [3:0] n);
        case (n)
            4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
            4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
            4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
            4'd10: return "R10"; 4'd11: return "R11"; 4'd12: return "R12";
            default: return "R13";
        endcase
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Drive one command, then wait to the next falling edge to observe it.
    task automatic issue(logic k, logic [3:0] p, logic [1:0] b, logic a);
        cke = k; pins = p; ba = b; a10 = a;
        @(negedge clk);
    endtask

    function automatic logic [2:0] st_of(int b);
        return bank_state[3*b +: 3];
    endfunction

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R3", "bank_state in reset", 32'(bank_state), 32'd0);
        rst_n = 1'b1;
        chk("R3", "viol after reset", 32'(viol), 32'd0);

        // Table walk: each vector's code must appear one edge later.
        for (int i = 0; i < NV; i++) begin
            issue(1'b1, VEC[i][9:6], VEC[i][5:4], VEC[i][3]);
            chk(tag(VEC[i][13:10]), $sformatf("vector %0d viol/code", i),
                {28'd0, viol, viol_code}, {28'd0, VEC[i][2:0] != 3'd0, VEC[i][2:0]});
        end

        // R5 / R4: activate timing, illegal repeat, one-cycle strobe.
        issue(1'b1, P_ACT, 2'd2, 1'b0);
        chk("R5", "bank2 activating", 32'(st_of(2)), 32'd1);
        issue(1'b1, P_ACT, 2'd2, 1'b0);
        chk("R5", "repeat activate code", {29'd0, viol_code}, 32'd2);
        chk("R4", "state after illegal activate", 32'(st_of(2)), 32'd2);
        issue(1'b1, P_NOP, 2'd0, 1'b0);
        chk("R4", "strobe lasts one cycle", 32'(viol), 32'd0);

        // R13: plain write holds for the burst, then row active.
        issue(1'b1, P_WR, 2'd2, 1'b0);
        chk("R13", "bank2 writing", 32'(st_of(2)), 32'd4);
        for (int i = 0; i < 3; i++) issue(1'b1, P_NOP, 2'd0, 1'b0);
        chk("R13", "last burst clock", 32'(st_of(2)), 32'd4);
        issue(1'b1, P_NOP, 2'd0, 1'b0);
        chk("R13", "burst over", 32'(st_of(2)), 32'd2);

        // R7: read with auto precharge returns to idle after burst + tRP.
        issue(1'b1, P_RD, 2'd2, 1'b1);
        chk("R7", "bank2 read auto precharge", 32'(st_of(2)), 32'd5);
        for (int i = 0; i < 4; i++) issue(1'b1, P_NOP, 2'd0, 1'b0);
        chk("R7", "last auto precharge clock", 32'(st_of(2)), 32'd5);
        issue(1'b1, P_NOP, 2'd0, 1'b0);
        chk("R7", "idle after auto precharge", 32'(st_of(2)), 32'd0);

        // R11: CKE falling and rising cycles are not judged.
        issue(1'b0, P_RD, 2'd0, 1'b0);
        chk("R11", "cke falling ignored", 32'(viol), 32'd0);
        issue(1'b1, P_RD, 2'd0, 1'b0);
        chk("R11", "cke rising ignored", 32'(viol), 32'd0);
        issue(1'b1, P_RD, 2'd0, 1'b0);
        chk("R11", "judged again", {28'd0, viol, viol_code}, {28'd0, 1'b1, 3'd1});

        // R10: self-refresh entry with an open row.
        issue(1'b1, P_ACT, 2'd0, 1'b0);
        issue(1'b1, P_NOP, 2'd0, 1'b0);
        issue(1'b0, P_REF, 2'd0, 1'b0);
        chk("R10", "self refresh with open row", {29'd0, viol_code}, 32'd4);
        issue(1'b0, P_NOP, 2'd0, 1'b0);
        issue(1'b1, P_NOP, 2'd0, 1'b0);
        issue(1'b1, P_PRE, 2'd0, 1'b0);
        issue(1'b1, P_NOP, 2'd0, 1'b0);
        chk("R6", "bank0 idle after precharge", 32'(st_of(0)), 32'd0);

        // R12: exit window after a legal self-refresh entry.
        issue(1'b0, P_REF, 2'd0, 1'b0);
        chk("R10", "legal self refresh entry", 32'(viol), 32'd0);
        issue(1'b0, P_NOP, 2'd0, 1'b0);
        issue(1'b0, P_NOP, 2'd0, 1'b0);
        issue(1'b1, P_RD, 2'd0, 1'b0);
        chk("R12", "exit clock 0 ignored", 32'(viol), 32'd0);
        issue(1'b1, P_RD, 2'd0, 1'b0);
        chk("R12", "exit clock 1 ignored", 32'(viol), 32'd0);
        issue(1'b1, P_RD, 2'd0, 1'b0);
        chk("R12", "exit clock 2 ignored", 32'(viol), 32'd0);
        issue(1'b1, P_RD, 2'd0, 1'b0);
        chk("R12", "judged after window", {28'd0, viol, viol_code}, {28'd0, 1'b1, 3'd1});

        // R3: reset in the middle of operation.
        issue(1'b1, P_ACT, 2'd1, 1'b0);
        rst_n = 1'b0;
        issue(1'b1, P_NOP, 2'd0, 1'b0);
        chk("R3", "mid-run reset idles banks", 32'(bank_state), 32'd0);
        rst_n = 1'b1;

        finish_run();
    end

endmodule